// File: doc/BRIEF.md
# System Control Register Block

This block is a bank of 32-bit control and status words that fills a 4 KB address window and is reached through an APB-style slave port with no wait states. Software can write any word and read it back. The block also turns certain writes into board-level requests: one word acts as a command word, and writing particular values to it raises a system reset request pulse or a power-off request pulse. The value written is stored in that word as well.

On reset, four words take fixed identification and configuration values and every other word clears to zero. Three status locations always return two fixed upper bits set when read. The stored contents do not change when those bits are added. Reads have no side effects. The logic that acts on the requests (real reset or power sequencing) lies outside this block.

Top module: `sysctl_regblk`

## Requirements
- R1: After reset, word index 0x40 (byte offset 0x100) holds 0x05F20121, index 0x41 holds 0x00000002, index 0x42 holds 0x05F30121 and index 0x43 holds 0x05F40121. Every other word holds zero.
- R2: A completed write (psel, penable and pwrite high on a clock edge) stores the full 32-bit pwdata in the word selected by paddr[11:2]. paddr[1:0] is ignored. A later read of any aligned offset returns what was last written there.
- R3: A completed write of value 1 or 2 to byte offset 0xF00 drives sys_reset_req high for exactly the one clock cycle that follows the completing edge.
- R4: A completed write of value 3 to byte offset 0xF00 drives sys_off_req high for exactly the one clock cycle that follows the completing edge.
- R5: Any other value written to offset 0xF00 raises neither request. Every write to 0xF00, whatever its value, is stored and reads back.
- R6: A read of byte offset 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000. The stored word itself is left unchanged. Reads of all other offsets return the stored word unmodified.
- R7: pready is always 1 and pslverr is always 0, so every access completes in its access phase.
- R8: A read changes no stored word and raises no request. prdata is captured from a register during the setup phase and is valid throughout the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address inside the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_off_req | output | 1 | One-cycle power-off request |

## Verification
The bench builds the block with its default parameters: a 12-bit address and 32-bit words. The full 1024-word window is therefore present, so random traffic can reach the lowest word, the highest word, the command word at 0xF00 and the three forced-bit status words together. Directed accesses cover the reset values, each command value from 0 to 5, and writes of zero to the forced locations. These writes show that the upper bits come from the read path and not from storage. Both request outputs are checked after every access, reads included.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helper functions for the system control block.
// Assumes 32-bit words. Word indices are byte offsets divided by four.
package sysctl_pkg;

    // Upper bits forced on reads of the status words
    localparam logic [31:0] STATUS_FORCE_BITS = 32'h3000_0000;

    // Reset value of a word, selected by word index
    function automatic logic [31:0] boot_value(input int unsigned word);
        case (word)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // True for word indices whose reads carry the forced bits
    function automatic logic is_status_word(input int unsigned word);
        return (word == 32'h40) || (word == 32'h42) || (word == 32'h43);
    endfunction

endpackage

// File: rtl/sysctl_store.sv
`timescale 1ns/1ps
// Module: word storage for the whole register window.
// Loads the boot values on synchronous active-low reset. One write port and one
// combinational read port. Assumes the write is already qualified by the caller.
module sysctl_store #(
    parameter int DATA_W = 32,
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WORD_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    import sysctl_pkg::*;

    localparam int WORDS = 1 << WORD_W;

    logic [DATA_W-1:0] mem [WORDS];

    // Load boot values on reset, otherwise store the full word on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= DATA_W'(boot_value(i));
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the addressed word to the read path
    always_comb begin
        rdata = mem[raddr];
    end

    // R8
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> (mem[$past(raddr)] == $past(mem[raddr])));

    // R2
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/sysctl_cmd.sv
`timescale 1ns/1ps
// Module: command word decoder.
// Watches completed writes to the command word and produces one-cycle request
// pulses. Assumes writes are at least two cycles apart, as the APB-style port
// guarantees.
module sysctl_cmd #(
    parameter int                DATA_W   = 32,
    parameter int                WORD_W   = 10,
    parameter logic [WORD_W-1:0] CMD_WORD = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [WORD_W-1:0] word_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              reset_req,
    output logic              off_req
);
    logic hit;
    logic want_reset;
    logic want_off;

    // Classify the write value when the command word is targeted
    always_comb begin
        hit        = wr_fire && (word_idx == CMD_WORD);
        want_reset = hit && ((wdata == DATA_W'(1)) || (wdata == DATA_W'(2)));
        want_off   = hit && (wdata == DATA_W'(3));
    end

    // Register the request pulses so each lasts one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
            off_req   <= 1'b0;
        end else begin
            reset_req <= want_reset;
            off_req   <= want_off;
        end
    end

    // R3
    reset_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(wr_fire && (word_idx == CMD_WORD)
                           && ((wdata == DATA_W'(1)) || (wdata == DATA_W'(2)))));

    // R4
    off_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |-> $past(wr_fire && (word_idx == CMD_WORD) && (wdata == DATA_W'(3))));

    // R5
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reset_req, off_req}));

    // R3
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

endmodule

// File: rtl/sysctl_rdpath.sv
`timescale 1ns/1ps
// Module: read data path.
// Captures the addressed word during the setup phase and adds the forced
// status bits for the status words. Assumes the address stays stable from setup
// to access.
module sysctl_rdpath #(
    parameter int DATA_W = 32,
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] word_idx,
    input  logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] rdata
);
    import sysctl_pkg::*;

    localparam logic [DATA_W-1:0] FORCE = DATA_W'(STATUS_FORCE_BITS);

    logic [DATA_W-1:0] shaped;

    // Add the forced bits for status words only
    always_comb begin
        shaped = stored;
        if (is_status_word(int'(word_idx))) begin
            shaped = stored | FORCE;
        end
    end

    // Register read data at the setup phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= shaped;
        end
    end

    // R6
    force_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && is_status_word(int'(word_idx))) |=> ((rdata & FORCE) == FORCE));

    // R6
    plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !is_status_word(int'(word_idx))) |=> (rdata == $past(stored)));

endmodule

// File: rtl/sysctl_regblk.sv
`timescale 1ns/1ps
// Module: system control register block, top level.
// APB-style slave with no wait states across a window of 2**ADDR_W bytes.
// Decodes accesses, stores words, drives request pulses and read data.
// Assumes aligned 32-bit accesses. Byte lanes and error responses are not used.
module sysctl_regblk #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int CMD_OFFSET = 'hF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              sys_reset_req,
    output logic              sys_off_req
);
    localparam int                WORD_W   = ADDR_W - 2;
    localparam logic [WORD_W-1:0] CMD_WORD = WORD_W'(CMD_OFFSET >> 2);

    logic [WORD_W-1:0] word_idx;
    logic              wr_fire;
    logic              rd_setup;
    logic [DATA_W-1:0] stored;
    logic              unused_addr_lsb;

    // Decode the access phase and the word index
    always_comb begin
        word_idx        = paddr[ADDR_W-1:2];
        wr_fire         = psel && penable && pwrite;
        rd_setup        = psel && !penable && !pwrite;
        unused_addr_lsb = ^paddr[1:0];
        pready          = 1'b1;
        pslverr         = 1'b0;
    end

    sysctl_store #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_fire),
        .waddr (word_idx),
        .wdata (pwdata),
        .raddr (word_idx),
        .rdata (stored)
    );

    sysctl_cmd #(.DATA_W(DATA_W), .WORD_W(WORD_W), .CMD_WORD(CMD_WORD)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fire   (wr_fire),
        .word_idx  (word_idx),
        .wdata     (pwdata),
        .reset_req (sys_reset_req),
        .off_req   (sys_off_req)
    );

    sysctl_rdpath #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rd_setup),
        .word_idx (word_idx),
        .stored   (stored),
        .rdata    (prdata)
    );

    // R8
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite) |=> !(sys_reset_req || sys_off_req));

endmodule

// File: tb/tb_sysctl_regblk.sv
`timescale 1ns/1ps
// Bench: seeded random traffic mixed with directed cases, checked against a bench model.
module tb_sysctl_regblk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, sys_reset_req, sys_off_req;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [1024];

    always #4 clk = ~clk;

    sysctl_regblk dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .sys_reset_req(sys_reset_req), .sys_off_req(sys_off_req)
    );

    function automatic logic [31:0] exp_boot(input int w);
        if (w == 'h40) return 32'h05F20121;
        if (w == 'h41) return 32'h00000002;
        if (w == 'h42) return 32'h05F30121;
        if (w == 'h43) return 32'h05F40121;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_read(input int w);
        if (w == 'h40 || w == 'h42 || w == 'h43) return model[w] | 32'h30000000;
        return model[w];
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        logic rr, ro;
        int w = int'(a[11:2]);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        chk(pready === 1'b1 && pslverr === 1'b0, "R7", {pready, pslverr}, 32'h2);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        rr = sys_reset_req; ro = sys_off_req;
        model[w] = d;
        if (w == 'h3C0 && (d == 1 || d == 2))
            chk(rr === 1'b1 && ro === 1'b0, "R3", {rr, ro}, 32'h2);
        else if (w == 'h3C0 && d == 3)
            chk(rr === 1'b0 && ro === 1'b1, "R4", {rr, ro}, 32'h1);
        else
            chk(rr === 1'b0 && ro === 1'b0, "R5", {rr, ro}, 32'h0);
        @(negedge clk);
        chk(sys_reset_req === 1'b0 && sys_off_req === 1'b0, "R3 R4 pulse width",
            {sys_reset_req, sys_off_req}, 32'h0);
    endtask

    task automatic do_read(input logic [11:0] a, input string req);
        logic [31:0] got;
        logic [31:0] exp = exp_read(int'(a[11:2]));
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        got = prdata;
        chk(pready === 1'b1 && pslverr === 1'b0, "R7", {pready, pslverr}, 32'h2);
        chk(got === exp, req, got, exp);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        // R8: a read raises no request
        chk(sys_reset_req === 1'b0 && sys_off_req === 1'b0, "R8",
            {sys_reset_req, sys_off_req}, 32'h0);
    endtask

    initial begin
        #1600000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 1024; i++) model[i] = exp_boot(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        chk(prdata === 32'h0 && sys_reset_req === 1'b0 && sys_off_req === 1'b0, "R1 outputs",
            prdata, 32'h0);
        do_read(12'h100, "R1 R6");
        do_read(12'h104, "R1");
        do_read(12'h108, "R1 R6");
        do_read(12'h10C, "R1 R6");
        do_read(12'h000, "R1");
        do_read(12'hFFC, "R1");
        // R2: full word, low address bits ignored
        do_write(12'h013, 32'hDEADBEEF);
        do_read(12'h010, "R2");
        do_read(12'hFFE, "R2");
        // R3 R4 R5: command values
        for (int v = 0; v <= 5; v++) begin
            do_write(12'hF00, 32'(v));
            do_read(12'hF00, "R5 stored");
        end
        do_write(12'hF00, 32'h00000101);
        do_read(12'hF01, "R5 stored");
        // R6: forced bits come only from the read path
        do_write(12'h108, 32'h0);
        do_read(12'h108, "R6");
        do_read(12'h108, "R6 repeat");
        do_write(12'h104, 32'h0);
        do_read(12'h104, "R6 unforced");
        do_write(12'h100, 32'hC00000AA);
        do_read(12'h100, "R6");
        // Random mix
        for (int n = 0; n < 400; n++) begin
            int sel = $urandom_range(0, 9);
            int w;
            logic [31:0] d;
            if (sel < 2) w = 'h3C0;
            else if (sel < 4) w = 'h40 + $urandom_range(0, 3);
            else w = $urandom_range(0, 1023);
            d = (w == 'h3C0) ? 32'($urandom_range(0, 5)) : $urandom;
            if ($urandom_range(0, 1) == 0)
                do_write({w[9:0], 2'($urandom_range(0, 3))}, d);
            else
                do_read({w[9:0], 2'($urandom_range(0, 3))}, "R2 R6 random");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule